// File: doc/BRIEF.md
# Exception Control Register Unit

This block is the privileged register bank that a 32-bit RISC core consults when control leaves the normal instruction stream. It keeps four registers: the return address of the faulting instruction, a cause word, the offending data address, and a status word. When the core signals an exception, the unit records where it happened and why. It also pushes a small stack of mode and interrupt-enable pairs, so the handler starts in kernel mode with interrupts off. When the core signals a return from exception, the unit pops that stack.

The unit also watches the hardware interrupt lines. It shows which levels are active in the cause word, even while interrupts are disabled. It raises a single interrupt request when the current enable bit is set and at least one active level is unmasked. Kernel software reads and writes the registers through a select-addressed port. While the core runs in user mode, the unit refuses all such writes.

Top module: `exc_ctl_regs`

## Requirements
- R1: After a synchronous reset, all four registers read 0, `user_mode` is 0 and `irq_out` is 0.
- R2: On `exc_req`, status bits 5:0 shift left by two and bits 1:0 become 0. Bit 0 is the enable bit (1 = enabled) and bit 1 is the mode bit (1 = user). As a result, `user_mode`, which always shows bit 1, reads 0 after the exception.
- R3: On `exc_req`, the return-address register loads `exc_pc`.
- R4: On `exc_req`, cause bits 5:2 load `exc_code`. The codes are: 0 interrupt, 4 address error on load or fetch, 5 address error on store, 6 fetch bus error, 7 data bus error, 8 syscall, 9 breakpoint, 10 reserved instruction, 12 overflow.
- R5: The bad-address register loads `exc_addr` only when the exception code is 4, 5, 6 or 7. For any other code it keeps its value.
- R6: When `rfe_req` is high without `exc_req`, status bits 3:0 take the old bits 5:2 and bits 5:4 keep their value. When both requests arrive in the same cycle, the exception is taken and the return is dropped.
- R7: Cause bits 14:10 show `irq_lines` as registered one clock earlier. This holds whatever the enable or mask state, and a bit clears when its line falls.
- R8: `irq_out` is 1 exactly when status bit 0 is 1 and, for some level i in 0..4, cause bit 10+i and mask bit 8+i are both 1.
- R9: Select codes are 0 status, 1 cause, 2 return address, 3 bad address, and reads are combinational. In status, only bits 15:8 and 5:0 can be written; the other bits read 0. In cause, only bits 5:2 can be written. The bad-address register cannot be written.
- R10: Software writes change nothing while status bit 1 is 1 (user mode).
- R11: A software write issued in the same cycle as `exc_req` or `rfe_req` is dropped, and the capture or return takes effect as normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Take an exception or interrupt this cycle |
| exc_code | input | 4 | Reason code for the exception |
| exc_pc | input | 32 | Address of the faulting instruction |
| exc_addr | input | 32 | Data address involved in the fault |
| irq_lines | input | 5 | Hardware interrupt lines, level sensitive |
| rfe_req | input | 1 | Return from exception this cycle |
| sw_wr_en | input | 1 | Software write strobe |
| sw_sel | input | 2 | Register select for the write |
| sw_wdata | input | 32 | Write data |
| sw_rd_sel | input | 2 | Register select for the read |
| sw_rdata | output | 32 | Read data |
| irq_out | output | 1 | Masked, enabled interrupt request to the core |
| user_mode | output | 1 | Current mode bit, 1 = user |

## Verification
The mode stack is driven through chains of pushes and pops that start from different bit patterns. These chains show whether each pair really moves one place, and whether the old pair is copied or cleared on a return. Exceptions are raised with memory codes and with non-memory codes, which separates unconditional capture of the bad address from capture gated by the code. Interrupt lines are driven at several levels while the mask and enable bits change, so that the pending bits, the mask and the enable can each be seen to decide the request on its own. Writes are issued in user mode, together with an exception, and together with a return, and then read back through the port to confirm that they had no effect.

// File: rtl/exc_ctl_pkg.sv
package exc_ctl_pkg;

    localparam int CODE_W = 4;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic user;
        logic ie;
    } mode_pair_t;

    typedef struct packed {
        mode_pair_t old_p;
        mode_pair_t prev_p;
        mode_pair_t cur_p;
    } mode_stack_t;

    localparam int STACK_W = $bits(mode_stack_t);

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_CAUSE  = 2'd1,
        SEL_EPC    = 2'd2,
        SEL_BADVA  = 2'd3
    } reg_sel_e;

    localparam code_t CODE_IRQ     = 4'd0;
    localparam code_t CODE_ADDR_LD = 4'd4;
    localparam code_t CODE_ADDR_ST = 4'd5;
    localparam code_t CODE_IBUS    = 4'd6;
    localparam code_t CODE_DBUS    = 4'd7;
    localparam code_t CODE_SYS     = 4'd8;
    localparam code_t CODE_BRK     = 4'd9;
    localparam code_t CODE_RSVD    = 4'd10;
    localparam code_t CODE_OVF     = 4'd12;

    function automatic logic code_has_addr(code_t c);
        return (c == CODE_ADDR_LD) || (c == CODE_ADDR_ST) ||
               (c == CODE_IBUS) || (c == CODE_DBUS);
    endfunction

    function automatic mode_stack_t stack_push(mode_stack_t s);
        mode_stack_t r;
        r.old_p  = s.prev_p;
        r.prev_p = s.cur_p;
        r.cur_p  = '0;
        return r;
    endfunction

    function automatic mode_stack_t stack_pop(mode_stack_t s);
        mode_stack_t r;
        r.old_p  = s.old_p;
        r.prev_p = s.old_p;
        r.cur_p  = s.prev_p;
        return r;
    endfunction

endpackage

// File: rtl/exc_mode_stack.sv
module exc_mode_stack
    import exc_ctl_pkg::*;
#(
    parameter int MASK_N = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_take,
    input  logic              ret_take,
    input  logic              wr_en,
    input  logic [MASK_N-1:0] wr_mask,
    input  mode_stack_t       wr_stack,
    output logic [MASK_N-1:0] mask_q,
    output mode_stack_t       stack_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            stack_q <= '0;
        end else if (exc_take) begin
            stack_q <= stack_push(stack_q);
        end else if (ret_take) begin
            stack_q <= stack_pop(stack_q);
        end else if (wr_en) begin
            mask_q  <= wr_mask;
            stack_q <= wr_stack;
        end
    end

    assert_exc_push_R2: assert property (@(posedge clk) disable iff (rst)
        exc_take |=> (stack_q.cur_p == 2'b00) &&
                     (stack_q.prev_p == $past(stack_q.cur_p)) &&
                     (stack_q.old_p == $past(stack_q.prev_p)));

    assert_ret_pop_R6: assert property (@(posedge clk) disable iff (rst)
        (ret_take && !exc_take) |=> (stack_q.old_p == $past(stack_q.old_p)) &&
                                    (stack_q.prev_p == $past(stack_q.old_p)) &&
                                    (stack_q.cur_p == $past(stack_q.prev_p)));

    assert_mask_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (exc_take || ret_take) |=> $stable(mask_q));

endmodule

// File: rtl/exc_cause_track.sv
module exc_cause_track
    import exc_ctl_pkg::*;
#(
    parameter int HW_N = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [HW_N-1:0] irq_lines,
    input  logic            exc_take,
    input  code_t           exc_code,
    input  logic            wr_en,
    input  code_t           wr_code,
    output logic [HW_N-1:0] pend_q,
    output code_t           code_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= irq_lines;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
        end else if (exc_take) begin
            code_q <= exc_code;
        end else if (wr_en) begin
            code_q <= wr_code;
        end
    end

    assert_code_cap_R4: assert property (@(posedge clk) disable iff (rst)
        exc_take |=> code_q == $past(exc_code));

    assert_pend_follow_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pend_q == $past(irq_lines));

endmodule

// File: rtl/exc_addr_capture.sv
module exc_addr_capture
    import exc_ctl_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            exc_take,
    input  code_t           exc_code,
    input  logic [XLEN-1:0] exc_pc,
    input  logic [XLEN-1:0] exc_addr,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] epc_q,
    output logic [XLEN-1:0] badva_q
);

    logic addr_fault;
    assign addr_fault = exc_take && code_has_addr(exc_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            epc_q <= '0;
        end else if (exc_take) begin
            epc_q <= exc_pc;
        end else if (wr_en) begin
            epc_q <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            badva_q <= '0;
        end else if (addr_fault) begin
            badva_q <= exc_addr;
        end
    end

    assert_epc_cap_R3: assert property (@(posedge clk) disable iff (rst)
        exc_take |=> epc_q == $past(exc_pc));

    assert_badva_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !(exc_take && (exc_code inside {4'd4, 4'd5, 4'd6, 4'd7})) |=> $stable(badva_q));

endmodule

// File: rtl/exc_ctl_regs.sv
module exc_ctl_regs
    import exc_ctl_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int HW_N   = 5,
    parameter int MASK_N = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            exc_req,
    input  logic [3:0]      exc_code,
    input  logic [XLEN-1:0] exc_pc,
    input  logic [XLEN-1:0] exc_addr,
    input  logic [HW_N-1:0] irq_lines,
    input  logic            rfe_req,
    input  logic            sw_wr_en,
    input  logic [1:0]      sw_sel,
    input  logic [XLEN-1:0] sw_wdata,
    input  logic [1:0]      sw_rd_sel,
    output logic [XLEN-1:0] sw_rdata,
    output logic            irq_out,
    output logic            user_mode
);

    localparam int MASK_LSB = 8;
    localparam int PEND_LSB = 10;
    localparam int CODE_LSB = 2;

    logic [MASK_N-1:0] mask_q;
    mode_stack_t       stack_q;
    logic [HW_N-1:0]   pend_q;
    code_t             code_q;
    logic [XLEN-1:0]   epc_q;
    logic [XLEN-1:0]   badva_q;

    logic     ret_take;
    logic     wr_ok;
    reg_sel_e wr_sel;
    reg_sel_e rd_sel;

    assign ret_take = rfe_req && !exc_req;
    assign wr_ok    = sw_wr_en && !stack_q.cur_p.user && !exc_req && !rfe_req;
    assign wr_sel   = reg_sel_e'(sw_sel);
    assign rd_sel   = reg_sel_e'(sw_rd_sel);

    exc_mode_stack #(.MASK_N(MASK_N)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .exc_take (exc_req),
        .ret_take (ret_take),
        .wr_en    (wr_ok && (wr_sel == SEL_STATUS)),
        .wr_mask  (sw_wdata[MASK_LSB +: MASK_N]),
        .wr_stack (mode_stack_t'(sw_wdata[STACK_W-1:0])),
        .mask_q   (mask_q),
        .stack_q  (stack_q)
    );

    exc_cause_track #(.HW_N(HW_N)) u_cause (
        .clk       (clk),
        .rst       (rst),
        .irq_lines (irq_lines),
        .exc_take  (exc_req),
        .exc_code  (exc_code),
        .wr_en     (wr_ok && (wr_sel == SEL_CAUSE)),
        .wr_code   (sw_wdata[CODE_LSB +: CODE_W]),
        .pend_q    (pend_q),
        .code_q    (code_q)
    );

    exc_addr_capture #(.XLEN(XLEN)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .exc_take (exc_req),
        .exc_code (exc_code),
        .exc_pc   (exc_pc),
        .exc_addr (exc_addr),
        .wr_en    (wr_ok && (wr_sel == SEL_EPC)),
        .wr_data  (sw_wdata),
        .epc_q    (epc_q),
        .badva_q  (badva_q)
    );

    logic [XLEN-1:0] status_word;
    logic [XLEN-1:0] cause_word;

    always_comb begin
        status_word = '0;
        status_word[MASK_LSB +: MASK_N] = mask_q;
        status_word[STACK_W-1:0] = stack_q;
        cause_word = '0;
        cause_word[PEND_LSB +: HW_N] = pend_q;
        cause_word[CODE_LSB +: CODE_W] = code_q;
    end

    always_comb begin
        case (rd_sel)
            SEL_STATUS: sw_rdata = status_word;
            SEL_CAUSE:  sw_rdata = cause_word;
            SEL_EPC:    sw_rdata = epc_q;
            default:    sw_rdata = badva_q;
        endcase
    end

    assign irq_out   = stack_q.cur_p.ie && |(pend_q & mask_q[HW_N-1:0]);
    assign user_mode = stack_q.cur_p.user;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (status_word == '0) && (epc_q == '0) && (badva_q == '0) && !irq_out);

    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (rst)
        !stack_q.cur_p.ie |-> !irq_out);

    assert_user_nowrite_R10: assert property (@(posedge clk) disable iff (rst)
        (sw_wr_en && user_mode && !exc_req && !rfe_req) |=>
            $stable(epc_q) && $stable(mask_q) && $stable(code_q) && $stable(stack_q));

    assert_badva_ro_R9: assert property (@(posedge clk) disable iff (rst)
        (sw_wr_en && !exc_req) |=> $stable(badva_q));

endmodule

// File: tb/sim_exc_ctl_regs.sv
module sim_exc_ctl_regs;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        exc_req;
    logic [3:0]  exc_code;
    logic [31:0] exc_pc;
    logic [31:0] exc_addr;
    logic [4:0]  irq_lines;
    logic        rfe_req;
    logic        sw_wr_en;
    logic [1:0]  sw_sel;
    logic [31:0] sw_wdata;
    logic [1:0]  sw_rd_sel;
    logic [31:0] sw_rdata;
    logic        irq_out;
    logic        user_mode;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_ctl_regs u0 (
        .clk(clk), .rst(rst), .exc_req(exc_req), .exc_code(exc_code),
        .exc_pc(exc_pc), .exc_addr(exc_addr), .irq_lines(irq_lines),
        .rfe_req(rfe_req), .sw_wr_en(sw_wr_en), .sw_sel(sw_sel),
        .sw_wdata(sw_wdata), .sw_rd_sel(sw_rd_sel), .sw_rdata(sw_rdata),
        .irq_out(irq_out), .user_mode(user_mode)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(logic [1:0] sel, logic [31:0] exp, string req, string what);
        sw_rd_sel = sel;
        #1;
        check(req, what, sw_rdata, exp);
    endtask

    task automatic sw_write(logic [1:0] sel, logic [31:0] data);
        sw_wr_en = 1'b1; sw_sel = sel; sw_wdata = data;
        step();
        sw_wr_en = 1'b0;
    endtask

    task automatic raise(logic [3:0] code, logic [31:0] pc, logic [31:0] addr);
        exc_req = 1'b1; exc_code = code; exc_pc = pc; exc_addr = addr;
        step();
        exc_req = 1'b0;
    endtask

    task automatic do_return();
        rfe_req = 1'b1;
        step();
        rfe_req = 1'b0;
    endtask

    task automatic t_reset();
        rd(2'd0, 32'h0, "R1", "status after reset");
        rd(2'd1, 32'h0, "R1", "cause after reset");
        rd(2'd2, 32'h0, "R1", "epc after reset");
        rd(2'd3, 32'h0, "R1", "badva after reset");
        check("R1", "user_mode after reset", {31'b0, user_mode}, 32'h0);
        check("R1", "irq_out after reset", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_access();
        sw_write(2'd0, 32'h0000_1F05);
        rd(2'd0, 32'h0000_1F05, "R9", "status write");
        sw_write(2'd0, 32'hFFFF_3FFD);
        rd(2'd0, 32'h0000_3F3D, "R9", "status fixed bits");
        sw_write(2'd3, 32'h0000_1234);
        rd(2'd3, 32'h0, "R9", "badva not writable");
        sw_write(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, 32'h0000_003C, "R9", "cause code only");
        sw_write(2'd2, 32'hDEAD_BEEF);
        rd(2'd2, 32'hDEAD_BEEF, "R9", "epc write");
    endtask

    task automatic t_exceptions();
        raise(4'd12, 32'h0000_0400, 32'h0000_0999);
        rd(2'd0, 32'h0000_3F34, "R2", "push after overflow");
        check("R2", "kernel after exc", {31'b0, user_mode}, 32'h0);
        rd(2'd2, 32'h0000_0400, "R3", "epc overflow");
        rd(2'd1, 32'h0000_0030, "R4", "cause overflow");
        rd(2'd3, 32'h0, "R5", "badva kept on overflow");
        raise(4'd5, 32'h0000_0500, 32'h0000_0ABC);
        rd(2'd0, 32'h0000_3F10, "R2", "second push");
        rd(2'd3, 32'h0000_0ABC, "R5", "badva on store addr error");
        rd(2'd1, 32'h0000_0014, "R4", "cause store addr error");
        rd(2'd2, 32'h0000_0500, "R3", "epc second");
    endtask

    task automatic t_return();
        do_return();
        rd(2'd0, 32'h0000_3F14, "R6", "first pop");
        do_return();
        rd(2'd0, 32'h0000_3F15, "R6", "second pop keeps old");
    endtask

    task automatic t_interrupts();
        irq_lines = 5'b00100;
        step();
        rd(2'd1, 32'h0000_1014, "R7", "pending level 2");
        check("R8", "irq enabled unmasked", {31'b0, irq_out}, 32'h1);
        sw_write(2'd0, 32'h0000_3B15);
        check("R8", "irq masked level 2", {31'b0, irq_out}, 32'h0);
        sw_write(2'd0, 32'h0000_3F14);
        check("R8", "irq ie off", {31'b0, irq_out}, 32'h0);
        rd(2'd1, 32'h0000_1014, "R7", "pending while disabled");
        irq_lines = 5'b00000;
        step();
        rd(2'd1, 32'h0000_0014, "R7", "pending cleared");
        sw_write(2'd0, 32'h0000_3F15);
        check("R8", "irq no pending", {31'b0, irq_out}, 32'h0);
        irq_lines = 5'b10000;
        step();
        check("R8", "irq level 4", {31'b0, irq_out}, 32'h1);
        irq_lines = 5'b00000;
        step();
        check("R8", "irq after line drop", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_user_block();
        sw_write(2'd0, 32'h0000_3F17);
        check("R2", "user_mode shows bit1", {31'b0, user_mode}, 32'h1);
        sw_write(2'd0, 32'h0000_0000);
        rd(2'd0, 32'h0000_3F17, "R10", "status write ignored");
        sw_write(2'd2, 32'h0000_0001);
        rd(2'd2, 32'h0000_0500, "R10", "epc write ignored");
        sw_write(2'd1, 32'h0000_0004);
        rd(2'd1, 32'h0000_0014, "R10", "cause write ignored");
    endtask

    task automatic t_priority();
        raise(4'd8, 32'h0000_0600, 32'h0000_0111);
        rd(2'd0, 32'h0000_3F1C, "R2", "push from user");
        check("R2", "kernel after syscall", {31'b0, user_mode}, 32'h0);
        rd(2'd1, 32'h0000_0020, "R4", "cause syscall");
        rd(2'd3, 32'h0000_0ABC, "R5", "badva kept on syscall");
        sw_wr_en = 1'b1; sw_sel = 2'd2; sw_wdata = 32'h0000_0777;
        raise(4'd9, 32'h0000_0700, 32'h0);
        sw_wr_en = 1'b0;
        rd(2'd2, 32'h0000_0700, "R11", "exc beats epc write");
        rd(2'd0, 32'h0000_3F30, "R2", "push on breakpoint");
        rfe_req = 1'b1;
        raise(4'd10, 32'h0000_0800, 32'h0);
        rfe_req = 1'b0;
        rd(2'd0, 32'h0000_3F00, "R6", "exc beats return");
        rd(2'd1, 32'h0000_0028, "R4", "cause reserved instr");
        sw_wr_en = 1'b1; sw_sel = 2'd2; sw_wdata = 32'h0000_0999;
        do_return();
        sw_wr_en = 1'b0;
        rd(2'd2, 32'h0000_0800, "R11", "return beats epc write");
        raise(4'd7, 32'h0000_0900, 32'h1234_5678);
        rd(2'd3, 32'h1234_5678, "R5", "badva on data bus error");
        raise(4'd0, 32'h0000_0A00, 32'h0000_FFFF);
        rd(2'd3, 32'h1234_5678, "R5", "badva kept on interrupt");
        rd(2'd1, 32'h0000_0000, "R4", "cause interrupt code");
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; exc_req = 1'b0; exc_code = '0; exc_pc = '0; exc_addr = '0;
        irq_lines = '0; rfe_req = 1'b0; sw_wr_en = 1'b0; sw_sel = '0;
        sw_wdata = '0; sw_rd_sel = '0;
        step();
        step();
        rst = 1'b0;
        t_reset();
        t_access();
        t_exceptions();
        t_return();
        t_interrupts();
        t_user_block();
        t_priority();
        summary();
        $finish;
    end

endmodule